// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit steers operand bypassing and load interlocks for a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory buffer and write-back. Each cycle it compares the source register numbers of the instruction sitting in decode against two destinations. The first is the destination of the instruction now in execute, which will occupy the EX/MEM result register on the next edge. The second is the destination now in EX/MEM, which will move on to MEM/WB.

From these comparisons it derives one bypass select for each of up to three source operands. It registers those selects so that they are ready at the start of the execute cycle of the dependent instruction. A younger producer always wins over an older one. Sources with no live match read the register file.

When the instruction in execute is a load and the instruction in decode reads its destination, forwarding cannot help, because the data arrives one stage too late. The unit then raises a stall that holds the program counter and the decode register, and inserts a no-op bubble into execute for exactly one cycle. On the next cycle the load sits in EX/MEM. The held instruction then proceeds with a select that takes the loaded value from the memory stage output.

Top module: `hazard_unit`

## Requirements
- R1: While `rst` is high, every field of `ex_fwd_sel` is 0 (register file).
- R2: If decode source i is valid, `idex_we` is 1, its index equals `idex_rd`, and no stall is raised, then on the next cycle field i of `ex_fwd_sel` (bits 2i+1:2i) is 1 (take the EX/MEM result).
- R3: If decode source i is valid and equals `exmem_rd` with `exmem_we` 1, but does not match a writing ID/EX instruction, and no stall is raised, then field i is 2 on the next cycle (take the MEM/WB result).
- R4: When a source matches both the writing ID/EX destination and the writing EX/MEM destination, the younger match wins and field i is 1.
- R5: A source whose valid bit is 0, or whose only matches are stages with write-enable 0, or that matches nothing, gets field value 0 on the next cycle.
- R6: `stall` and `bubble` are 1 in the same cycle in which `idex_we` and `idex_ld` are 1 and some valid decode source equals `idex_rd`.
- R7: `stall` and `bubble` are 0 when the ID/EX instruction is not a writing load, or when no valid decode source equals its destination.
- R8: In the cycle after a stall, every field of `ex_fwd_sel` is 0, because execute holds a bubble.
- R9: The three source fields are resolved independently, so one cycle can carry different select values in different fields.
- R10: A load-use pair costs exactly one stall cycle. Once the load has moved to EX/MEM, `stall` is 0 and the held instruction gets field value 2 for the loaded register on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_idx | input | N_SRC*IDX_W | Decode-stage source register numbers, source i at bits i*IDX_W +: IDX_W |
| dec_src_vld | input | N_SRC | Source i is actually read by the decode instruction |
| idex_rd | input | IDX_W | Destination of the instruction in execute |
| idex_we | input | 1 | Instruction in execute writes a register |
| idex_ld | input | 1 | Instruction in execute is a load |
| exmem_rd | input | IDX_W | Destination held in the EX/MEM register |
| exmem_we | input | 1 | EX/MEM instruction writes a register |
| stall | output | 1 | Hold the program counter and the decode register |
| bubble | output | 1 | Load a no-op into execute |
| ex_fwd_sel | output | N_SRC*2 | Execute operand selects: 0 register file, 1 EX/MEM, 2 MEM/WB |

## Verification
The selects are computed one cycle ahead and held in registers. A wrong comparison or a wrong priority therefore shows up at `ex_fwd_sel` exactly one cycle after the offending decode pattern, and only in the field of the affected source. A faulty load-use term shows at `stall` and `bubble` within the same cycle. A select register that fails to clear on a stall leaves a nonzero field one cycle after the stall. The sweep walks every combination of small register numbers, the three stage flags and the source valid bits, so each of these faults meets a pattern that exposes it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF    = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic young;   // match against the stage that becomes EX/MEM
        logic old;     // match against the stage that becomes MEM/WB
    } hit_pair_t;

    // Priority resolution: a bubble clears, the younger producer wins.
    function automatic fwd_sel_e resolve_sel(hit_pair_t h, logic kill);
        if (kill)
            return FWD_RF;
        else if (h.young)
            return FWD_EXMEM;
        else if (h.old)
            return FWD_MEMWB;
        else
            return FWD_RF;
    endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             src_vld,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_we,
    output logic             hit
);
    always_comb begin
        hit = src_vld && dst_we && (src_idx == dst_idx);
    end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
    parameter int IDX_W = 4,
    parameter int N_SRC = 3
) (
    input  logic [N_SRC*IDX_W-1:0] src_idx,
    input  logic [N_SRC-1:0]       src_vld,
    input  logic [IDX_W-1:0]       ld_rd,
    input  logic                   ld_we,
    input  logic                   ld_is_load,
    output logic                   use_hit
);
    logic [N_SRC-1:0] per_src;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        hzd_match #(.IDX_W(IDX_W)) u_match (
            .src_idx (src_idx[i*IDX_W +: IDX_W]),
            .src_vld (src_vld[i]),
            .dst_idx (ld_rd),
            .dst_we  (ld_we && ld_is_load),
            .hit     (per_src[i])
        );
    end

    always_comb begin
        use_hit = |per_src;
    end
endmodule

// File: rtl/hzd_sel_stage.sv
module hzd_sel_stage
    import hzd_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int N_SRC = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC*IDX_W-1:0] src_idx,
    input  logic [N_SRC-1:0]       src_vld,
    input  logic [IDX_W-1:0]       young_rd,
    input  logic                   young_we,
    input  logic [IDX_W-1:0]       old_rd,
    input  logic                   old_we,
    input  logic                   kill,
    output logic [N_SRC*SEL_W-1:0] sel_flat
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        hit_pair_t hits;
        fwd_sel_e  sel_d;
        fwd_sel_e  sel_q;

        hzd_match #(.IDX_W(IDX_W)) u_young (
            .src_idx (src_idx[i*IDX_W +: IDX_W]),
            .src_vld (src_vld[i]),
            .dst_idx (young_rd),
            .dst_we  (young_we),
            .hit     (hits.young)
        );

        hzd_match #(.IDX_W(IDX_W)) u_old (
            .src_idx (src_idx[i*IDX_W +: IDX_W]),
            .src_vld (src_vld[i]),
            .dst_idx (old_rd),
            .dst_we  (old_we),
            .hit     (hits.old)
        );

        always_comb begin
            sel_d = resolve_sel(hits, kill);
        end

        always_ff @(posedge clk) begin
            if (rst)
                sel_q <= FWD_RF;
            else
                sel_q <= sel_d;
        end

        assign sel_flat[i*SEL_W +: SEL_W] = sel_q;
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hzd_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int N_SRC = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC*IDX_W-1:0] dec_src_idx,
    input  logic [N_SRC-1:0]       dec_src_vld,
    input  logic [IDX_W-1:0]       idex_rd,
    input  logic                   idex_we,
    input  logic                   idex_ld,
    input  logic [IDX_W-1:0]       exmem_rd,
    input  logic                   exmem_we,
    output logic                   stall,
    output logic                   bubble,
    output logic [N_SRC*2-1:0]     ex_fwd_sel
);
    logic load_use;

    hzd_loaduse #(.IDX_W(IDX_W), .N_SRC(N_SRC)) u_loaduse (
        .src_idx    (dec_src_idx),
        .src_vld    (dec_src_vld),
        .ld_rd      (idex_rd),
        .ld_we      (idex_we),
        .ld_is_load (idex_ld),
        .use_hit    (load_use)
    );

    // The ID/EX producer lands in EX/MEM next edge; EX/MEM moves to MEM/WB.
    hzd_sel_stage #(.IDX_W(IDX_W), .N_SRC(N_SRC)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .src_idx  (dec_src_idx),
        .src_vld  (dec_src_vld),
        .young_rd (idex_rd),
        .young_we (idex_we),
        .old_rd   (exmem_rd),
        .old_we   (exmem_we),
        .kill     (load_use),
        .sel_flat (ex_fwd_sel)
    );

    always_comb begin
        stall  = load_use;
        bubble = load_use;
    end
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int IDX_W = 4,
    parameter int N_SRC = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_SRC*IDX_W-1:0] dec_src_idx,
    input logic [N_SRC-1:0]       dec_src_vld,
    input logic [IDX_W-1:0]       idex_rd,
    input logic                   idex_we,
    input logic                   idex_ld,
    input logic [IDX_W-1:0]       exmem_rd,
    input logic                   exmem_we,
    input logic                   stall,
    input logic                   bubble,
    input logic [N_SRC*2-1:0]     ex_fwd_sel
);
    // R8
    bubble_clears_sel_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (ex_fwd_sel == '0));

    // R6
    bubble_with_stall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> bubble);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // R6
        load_use_stall_chk: assert property (@(posedge clk) disable iff (rst)
            (idex_we && idex_ld && dec_src_vld[i] &&
             dec_src_idx[i*IDX_W +: IDX_W] == idex_rd) |-> stall);

        // R2
        young_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            (!stall && dec_src_vld[i] && idex_we &&
             dec_src_idx[i*IDX_W +: IDX_W] == idex_rd)
            |=> (ex_fwd_sel[i*2 +: 2] == 2'd1));

        // R3
        old_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            (!stall && dec_src_vld[i] && exmem_we &&
             dec_src_idx[i*IDX_W +: IDX_W] == exmem_rd &&
             !(idex_we && dec_src_idx[i*IDX_W +: IDX_W] == idex_rd))
            |=> (ex_fwd_sel[i*2 +: 2] == 2'd2));

        // R5
        unused_src_chk: assert property (@(posedge clk) disable iff (rst)
            !dec_src_vld[i] |=> (ex_fwd_sel[i*2 +: 2] == 2'd0));
    end
endmodule

bind hazard_unit hazard_unit_chk #(.IDX_W(IDX_W), .N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_src_idx (dec_src_idx),
    .dec_src_vld (dec_src_vld),
    .idex_rd     (idex_rd),
    .idex_we     (idex_we),
    .idex_ld     (idex_ld),
    .exmem_rd    (exmem_rd),
    .exmem_we    (exmem_we),
    .stall       (stall),
    .bubble      (bubble),
    .ex_fwd_sel  (ex_fwd_sel)
);

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
    localparam int IDX_W = 4;
    localparam int N_SRC = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                   rst;
    logic [N_SRC*IDX_W-1:0] src;
    logic [N_SRC-1:0]       vld;
    logic [IDX_W-1:0]       idex_rd, exmem_rd;
    logic                   idex_we, idex_ld, exmem_we;
    logic                   stall, bubble;
    logic [N_SRC*2-1:0]     sel;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int    exp_sel [N_SRC];
    string exp_tag [N_SRC];
    bit    pending = 0;

    hazard_unit #(.IDX_W(IDX_W), .N_SRC(N_SRC)) uut (
        .clk(clk), .rst(rst), .dec_src_idx(src), .dec_src_vld(vld),
        .idex_rd(idex_rd), .idex_we(idex_we), .idex_ld(idex_ld),
        .exmem_rd(exmem_rd), .exmem_we(exmem_we),
        .stall(stall), .bubble(bubble), .ex_fwd_sel(sel)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int src_of(int i);
        return int'(src[i*IDX_W +: IDX_W]);
    endfunction

    // Called right after inputs change at a falling edge.
    task automatic eval();
        bit es;
        bit y, o;
        if (pending)
            for (int i = 0; i < N_SRC; i++)
                check(exp_tag[i], int'(sel[i*2 +: 2]), exp_sel[i]);
        #1;
        es = 0;
        for (int i = 0; i < N_SRC; i++)
            if (vld[i] && idex_we && idex_ld && src_of(i) == int'(idex_rd)) es = 1;
        check(es ? "R6 stall" : "R7 stall", int'(stall), int'(es));
        check(es ? "R6 bubble" : "R7 bubble", int'(bubble), int'(es));
        for (int i = 0; i < N_SRC; i++) begin
            y = vld[i] && idex_we && src_of(i) == int'(idex_rd);
            o = vld[i] && exmem_we && src_of(i) == int'(exmem_rd);
            if (es)          begin exp_sel[i] = 0; exp_tag[i] = "R8"; end
            else if (y && o) begin exp_sel[i] = 1; exp_tag[i] = "R4"; end
            else if (y)      begin exp_sel[i] = 1; exp_tag[i] = "R2"; end
            else if (o)      begin exp_sel[i] = 2; exp_tag[i] = "R3"; end
            else             begin exp_sel[i] = 0; exp_tag[i] = "R5"; end
        end
        pending = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pending)
            for (int i = 0; i < N_SRC; i++)
                check(exp_tag[i], int'(sel[i*2 +: 2]), exp_sel[i]);
        pending = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: matching inputs during reset must not move the selects
        rst = 1'b1;
        vld = '1; src = {4'd3, 4'd3, 4'd3};
        idex_rd = 4'd3; idex_we = 1'b1; idex_ld = 1'b0;
        exmem_rd = 4'd3; exmem_we = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < N_SRC; i++) check("R1", int'(sel[i*2 +: 2]), 0);
        rst = 1'b0;

        // Sweep: small register numbers, all stage flags, all valid patterns
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int f = 0; f < 8; f++)
                    for (int s = 0; s < 4; s++)
                        for (int v = 0; v < 8; v++) begin
                            @(negedge clk);
                            idex_rd  = IDX_W'(a);
                            exmem_rd = IDX_W'(b);
                            idex_we  = f[0];
                            idex_ld  = f[1];
                            exmem_we = f[2];
                            src[0*IDX_W +: IDX_W] = IDX_W'(s);
                            src[1*IDX_W +: IDX_W] = IDX_W'((s + 1) % 4);
                            src[2*IDX_W +: IDX_W] = IDX_W'(s ^ 2);
                            vld = 3'(v);
                            eval();
                        end
        flush();

        // R9: three fields carry three different selects at once
        idex_rd = 4'd3; idex_we = 1'b1; idex_ld = 1'b0;
        exmem_rd = 4'd7; exmem_we = 1'b1;
        vld = 3'b111; src = {4'd9, 4'd7, 4'd3};
        @(negedge clk);
        check("R9 field0", int'(sel[1:0]), 1);
        check("R9 field1", int'(sel[3:2]), 2);
        check("R9 field2", int'(sel[5:4]), 0);

        // R10: load r5 followed by a user of r5
        idex_rd = 4'd5; idex_we = 1'b1; idex_ld = 1'b1;
        exmem_rd = 4'd1; exmem_we = 1'b0;
        vld = 3'b001; src = {4'd0, 4'd0, 4'd5};
        #1;
        check("R10 stall raised", int'(stall), 1);
        @(negedge clk);
        // load advanced to EX/MEM, bubble in execute, user held in decode
        check("R10 bubble selects", int'(sel[1:0]), 0);
        idex_we = 1'b0; idex_ld = 1'b0; idex_rd = 4'd0;
        exmem_rd = 4'd5; exmem_we = 1'b1;
        #1;
        check("R10 single stall", int'(stall), 0);
        @(negedge clk);
        check("R10 load data from memory stage", int'(sel[1:0]), 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule